// File: doc/BRIEF.md
# Reference Selection and PLL Mode Controller

This block picks which of several monitored input clocks serves as the reference for a digital PLL, and it steps the PLL through its operating modes. Each input carries a qualification flag and a programmable priority. In automatic selection the highest-priority qualified input wins. In manual selection software names the input directly. A revertive switch decides whether the block returns to a better input once that input requalifies.

The controller tracks four modes: free-run, acquiring, locked and holdover. A lock flag from the loop moves the block from acquiring to locked. When no usable reference remains, the block drops into holdover within one cycle. A bandwidth-select output tells the loop filter to use its narrow locked bandwidth only while locked. Each change of reference during active tracking raises a one-cycle phase-build-out pulse, so the loop can absorb the phase step and the switch stays hitless. Software can also ask for a build-out pulse.

All outputs are registered. A change on any input shows up at the outputs after the next rising clock edge.

Top module: `ref_select_ctrl`

## Requirements
- R1: While `rst_n` is low and right after it is released, `mode_o` is free-run (0), `sel_idx_o` is 0, `pbo_o` is 0 and `bw_lock_o` is 0.
- R2: The mode codes are free-run=0, acquiring=1, locked=2 and holdover=3. Free-run moves to acquiring when a usable reference exists. Acquiring moves to locked when `lock_i` is high. Locked is entered only from acquiring, never straight from free-run or holdover.
- R3: In automatic mode (`auto_sel_i`=1) the block selects the qualified input with the highest priority. Input k's priority is the 4-bit field `prio_i[4k+3:4k]`. Among equal priorities the lowest index wins. A priority of 0 excludes the input from automatic selection.
- R4: With `revert_i`=1 in automatic mode, the block leaves the current input for another qualified input only when that input's priority is strictly higher than the current one's.
- R5: With `revert_i`=0 in automatic mode, the block stays on the current input for as long as it remains qualified and its priority is nonzero.
- R6: If no usable reference exists, locked and acquiring move to holdover one cycle later. The exception is acquiring that has never reached locked since reset, which returns to free-run instead. Holdover moves to acquiring once a usable reference reappears, and `sel_idx_o` holds its last value while no reference is used.
- R7: In manual mode (`auto_sel_i`=0) the input `man_idx_i` is used whenever it is qualified, regardless of its priority. If it is unqualified or out of range (at least 3), the block leaves the active modes rather than switching to another input.
- R8: `bw_lock_o` is 1 exactly while the mode is locked, and 0 in every other mode.
- R9: `pbo_o` pulses for one cycle when the selected input changes while the block is already acquiring or locked. It does not pulse on the first selection out of free-run or holdover.
- R10: With `pbo_req_i` high in locked mode and a usable reference present, `pbo_o` is 1 after the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid_i | input | 3 | Per-input qualification flags |
| prio_i | input | 12 | Priorities, 4 bits per input, input k at bits 4k+3:4k |
| auto_sel_i | input | 1 | 1 = automatic selection, 0 = manual |
| man_idx_i | input | 2 | Manually chosen input index |
| revert_i | input | 1 | Revertive selection enable |
| lock_i | input | 1 | Lock indication from the loop |
| pbo_req_i | input | 1 | Software phase-build-out request |
| sel_idx_o | output | 2 | Selected reference index |
| mode_o | output | 2 | Mode: 0 free-run, 1 acquiring, 2 locked, 3 holdover |
| bw_lock_o | output | 1 | 1 = use locked bandwidth, 0 = acquisition bandwidth |
| pbo_o | output | 1 | One-cycle phase-build-out trigger |

## Verification
Selection is tested with several distinct priority sets. One set has all priorities distinct. Another has all priorities equal, which tells the index tie-break apart from the priority ordering. A third gives one input priority zero while that input stays qualified, so exclusion shows up separately from loss of qualification. Failing and requalifying a higher-priority input with `revert_i` set and then cleared separates revertive from non-revertive behaviour. Removing every qualification both with and without prior lock separates the holdover exit from the return to free-run. Manual runs with an unqualified index and an out-of-range index show that the block does not fall back to automatic choice.

// File: rtl/ref_select_ctrl.sv
module ref_select_ctrl #(
  parameter int N_IN = 3,
  parameter int PW   = 4,
  localparam int IW  = (N_IN > 1) ? $clog2(N_IN) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IN-1:0]  in_valid_i,
  input  logic [N_IN*PW-1:0] prio_i,
  input  logic             auto_sel_i,
  input  logic [IW-1:0]    man_idx_i,
  input  logic             revert_i,
  input  logic             lock_i,
  input  logic             pbo_req_i,
  output logic [IW-1:0]    sel_idx_o,
  output logic [1:0]       mode_o,
  output logic             bw_lock_o,
  output logic             pbo_o
);

  typedef enum logic [1:0] {M_FREE = 2'd0, M_ACQ = 2'd1, M_LOCK = 2'd2, M_HOLD = 2'd3} mode_t;

  mode_t         mode_q, mode_d;
  logic [IW-1:0] sel_q, sel_d, target, best_idx;
  logic [PW-1:0] best_prio, cur_prio;
  logic          best_ok, cur_ok, man_ok, avail, active, hist_q, pbo_q, pbo_d;

  function automatic logic [PW-1:0] prio_at(input logic [IW-1:0] k);
    prio_at = '0;
    for (int i = 0; i < N_IN; i++)
      if (k == IW'(i)) prio_at = prio_i[i*PW +: PW];
  endfunction

  function automatic logic valid_at(input logic [IW-1:0] k);
    valid_at = 1'b0;
    for (int i = 0; i < N_IN; i++)
      if (k == IW'(i)) valid_at = in_valid_i[i];
  endfunction

  assign active = (mode_q == M_ACQ) || (mode_q == M_LOCK);

  // R3: strict compare keeps the lowest index on ties; zero priority never qualifies
  always_comb begin
    best_ok   = 1'b0;
    best_idx  = '0;
    best_prio = '0;
    for (int i = 0; i < N_IN; i++) begin
      if (in_valid_i[i] && prio_i[i*PW +: PW] > best_prio) begin
        best_ok   = 1'b1;
        best_idx  = IW'(i);
        best_prio = prio_i[i*PW +: PW];
      end
    end
  end

  assign cur_prio = prio_at(sel_q);
  assign cur_ok   = active && valid_at(sel_q) && (cur_prio != '0);
  assign man_ok   = valid_at(man_idx_i);

  // R4 / R5 / R7
  always_comb begin
    if (!auto_sel_i) begin
      target = man_idx_i;
      avail  = man_ok;
    end else if (cur_ok && !(revert_i && best_ok && best_prio > cur_prio)) begin
      target = sel_q;
      avail  = 1'b1;
    end else begin
      target = best_idx;
      avail  = best_ok;
    end
  end

  assign sel_d = avail ? target : sel_q;
  // R9 / R10
  assign pbo_d = (active && avail && target != sel_q) ||
                 (pbo_req_i && mode_q == M_LOCK && avail);

  // R2 / R6
  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      M_FREE: if (avail) mode_d = M_ACQ;
      M_ACQ:  if (!avail) mode_d = hist_q ? M_HOLD : M_FREE;
              else if (lock_i) mode_d = M_LOCK;
      M_LOCK: if (!avail) mode_d = M_HOLD;
      M_HOLD: if (avail) mode_d = M_ACQ;
      default: mode_d = M_FREE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= M_FREE;
      sel_q  <= '0;
      pbo_q  <= 1'b0;
      hist_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      sel_q  <= sel_d;
      pbo_q  <= pbo_d;
      if (mode_d == M_LOCK) hist_q <= 1'b1;
    end
  end

  assign sel_idx_o = sel_q;
  assign mode_o    = mode_q;
  assign bw_lock_o = (mode_q == M_LOCK);
  assign pbo_o     = pbo_q;

  a_r2_lock_via_acq: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_LOCK && $past(mode_q) != M_LOCK) |-> $past(mode_q) == M_ACQ);

  a_r6_hold_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_HOLD && $past(mode_q) != M_HOLD) |->
      ($past(mode_q) == M_LOCK || $past(mode_q) == M_ACQ));

  a_r6_no_input_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i == '0) |=> (mode_o == 2'd0 || mode_o == 2'd3));

  a_r7_manual_bad: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_sel_i && !man_ok) |=> !(mode_o == 2'd1 || mode_o == 2'd2));

  a_r8_bw_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bw_lock_o) |-> $past(mode_q) == M_ACQ);

  a_r9_switch_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && sel_q != $past(sel_q)) |-> pbo_o);

  a_r9_pulse_active: assert property (@(posedge clk) disable iff (!rst_n)
    pbo_o |-> (mode_o == 2'd1 || mode_o == 2'd2));

endmodule

// File: tb/ref_select_ctrl_bench.sv
module ref_select_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 21;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] in_valid;
  logic [11:0] prio;
  logic auto_sel, revert, lock, pbo_req;
  logic [1:0] man_idx, sel_idx, mode;
  logic bw_lock, pbo;
  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ref_select_ctrl u_ref_select_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid), .prio_i(prio),
    .auto_sel_i(auto_sel), .man_idx_i(man_idx), .revert_i(revert),
    .lock_i(lock), .pbo_req_i(pbo_req), .sel_idx_o(sel_idx),
    .mode_o(mode), .bw_lock_o(bw_lock), .pbo_o(pbo));

  // {valid, prio{p2,p1,p0}, auto, man, rev, lock, preq, exp_sel, exp_mode, exp_pbo, req}
  localparam logic [29:0] VEC [NV] = '{
    {3'b111, 12'h352, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 2'd1, 2'd1, 1'b0, 4'd3},  // R3 best pick, R2 acquire
    {3'b111, 12'h352, 1'b1, 2'd0, 1'b1, 1'b1, 1'b0, 2'd1, 2'd2, 1'b0, 4'd2},  // R2 lock
    {3'b101, 12'h352, 1'b1, 2'd0, 1'b1, 1'b1, 1'b0, 2'd2, 2'd2, 1'b1, 4'd9},  // R9 switch pulse
    {3'b101, 12'h352, 1'b1, 2'd0, 1'b1, 1'b1, 1'b0, 2'd2, 2'd2, 1'b0, 4'd9},  // R9 single cycle
    {3'b111, 12'h352, 1'b1, 2'd0, 1'b1, 1'b1, 1'b0, 2'd1, 2'd2, 1'b1, 4'd4},  // R4 revert
    {3'b101, 12'h352, 1'b1, 2'd0, 1'b1, 1'b1, 1'b0, 2'd2, 2'd2, 1'b1, 4'd9},
    {3'b111, 12'h352, 1'b1, 2'd0, 1'b0, 1'b1, 1'b0, 2'd2, 2'd2, 1'b0, 4'd5},  // R5 stay
    {3'b111, 12'h222, 1'b1, 2'd0, 1'b1, 1'b1, 1'b0, 2'd2, 2'd2, 1'b0, 4'd4},  // R4 equal prio no switch
    {3'b011, 12'h222, 1'b1, 2'd0, 1'b1, 1'b1, 1'b0, 2'd0, 2'd2, 1'b1, 4'd3},  // R3 tie -> lower index
    {3'b011, 12'h240, 1'b1, 2'd0, 1'b1, 1'b1, 1'b0, 2'd1, 2'd2, 1'b1, 4'd3},  // R3 zero excludes
    {3'b000, 12'h240, 1'b1, 2'd0, 1'b1, 1'b1, 1'b0, 2'd1, 2'd3, 1'b0, 4'd6},  // R6 holdover
    {3'b000, 12'h240, 1'b1, 2'd0, 1'b1, 1'b1, 1'b0, 2'd1, 2'd3, 1'b0, 4'd6},
    {3'b001, 12'h240, 1'b1, 2'd0, 1'b1, 1'b1, 1'b0, 2'd1, 2'd3, 1'b0, 4'd3},  // R3 excluded only input
    {3'b100, 12'h240, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 2'd2, 2'd1, 1'b0, 4'd8},  // R8 acq bandwidth
    {3'b100, 12'h240, 1'b1, 2'd0, 1'b1, 1'b1, 1'b0, 2'd2, 2'd2, 1'b0, 4'd2},
    {3'b111, 12'h240, 1'b0, 2'd0, 1'b1, 1'b1, 1'b0, 2'd0, 2'd2, 1'b1, 4'd7},  // R7 manual ignores prio
    {3'b101, 12'h240, 1'b0, 2'd1, 1'b1, 1'b1, 1'b0, 2'd0, 2'd3, 1'b0, 4'd7},  // R7 invalid -> holdover
    {3'b111, 12'h240, 1'b0, 2'd1, 1'b1, 1'b0, 1'b0, 2'd1, 2'd1, 1'b0, 4'd6},
    {3'b111, 12'h240, 1'b0, 2'd1, 1'b1, 1'b1, 1'b0, 2'd1, 2'd2, 1'b0, 4'd2},
    {3'b111, 12'h240, 1'b0, 2'd1, 1'b1, 1'b1, 1'b1, 2'd1, 2'd2, 1'b1, 4'd10}, // R10 request
    {3'b111, 12'h240, 1'b0, 2'd1, 1'b1, 1'b1, 1'b0, 2'd1, 2'd2, 1'b0, 4'd10}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req, input int es, input int em, input int ep);
    chk(req, "sel", int'(sel_idx), es);
    chk(req, "mode", int'(mode), em);
    chk(req, "pbo", int'(pbo), ep);
    chk(req, "bw (R8)", int'(bw_lock), (em == 2) ? 1 : 0);
  endtask

  task automatic drive(input logic [2:0] v, input logic [11:0] p, input logic a,
                       input logic [1:0] m, input logic r, input logic l, input logic q);
    in_valid = v; prio = p; auto_sel = a; man_idx = m; revert = r; lock = l; pbo_req = q;
  endtask

  task automatic step();
    @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    step();
    step();
    rst_n = 1'b1;
  endtask

  initial begin
    drive(3'b000, 12'h000, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0);
    step();
    check_all("R1", 0, 0, 0);
    do_reset();
    check_all("R1", 0, 0, 0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][29:27], VEC[i][26:15], VEC[i][14], VEC[i][13:12],
            VEC[i][11], VEC[i][10], VEC[i][9]);
      step();
      check_all($sformatf("R%0d", VEC[i][3:0]), int'(VEC[i][8:7]),
                int'(VEC[i][6:5]), int'(VEC[i][4]));
    end

    // R1 mid-run reset
    do_reset();
    check_all("R1", 0, 0, 0);
    // R6: acquiring without prior lock falls back to free-run
    drive(3'b010, 12'h010, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0);
    step();
    check_all("R6", 1, 1, 0);
    drive(3'b000, 12'h010, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0);
    step();
    check_all("R6", 1, 0, 0);
    // R7: out-of-range manual index keeps free-run
    drive(3'b111, 12'h111, 1'b0, 2'd3, 1'b1, 1'b1, 1'b0);
    step();
    check_all("R7", 1, 0, 0);
    // R2: lock flag already high still passes through acquiring
    drive(3'b001, 12'h001, 1'b1, 2'd0, 1'b1, 1'b1, 1'b0);
    step();
    check_all("R2", 0, 1, 0);
    step();
    check_all("R2", 0, 2, 0);
    // R10: request ignored outside locked
    drive(3'b000, 12'h001, 1'b1, 2'd0, 1'b1, 1'b1, 1'b1);
    step();
    check_all("R10", 0, 3, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule